// File: doc/BRIEF.md
# Command-Queued SPI Master Engine

This block is an SPI master whose transmit side is fed by a queue of 32-bit push entries. Each entry pairs a 16-bit command half with a 16-bit data half. The command half travels with the data through the queue, so chip-select continuity, halting at the end of a batch and restarting the transfer counter are all decided per frame inside the data stream. Software or a DMA engine can therefore hand over a whole sequence of frames at once and collect the result later.

Received frames, masked to the frame width, go into a receive queue that is read through a pop port. Six chip selects are driven, each with a programmable inactive level. A 16-bit transfer counter and a set of sticky status flags, each cleared by writing one, report progress. The serial clock timing comes from an external timing unit as a tick strobe. Every tick moves the serial clock by one half period. Frames are sent MSB first in SPI mode 0: the clock idles low, the input is sampled on the rising edge and the output changes on the falling edge.

Top module: `cq_spi_master`

## Requirements
- R1: The push entry layout is: bit 31 continuous select, bits 30:28 attribute set, bit 27 end of queue, bit 26 counter clear, bits 25:22 ignored, bits 21:16 one-hot chip selects, bits 15:0 data. A push into a full transmit queue (4 entries by default) is dropped.
- R2: The frame length is the frame-size field of the chosen attribute set plus one, with field values below 3 acting as 3. Data leave on mosi MSB first. sck idles low and makes one rising and one falling edge per bit, each edge on a tick.
- R3: The received frame, masked to the frame width, is stored in the receive queue. pop_valid flags a waiting word, pop_data shows the oldest word, and pop_req removes it.
- R4: A selected chip select is driven to the inverse of its ctl_cs_idle bit. An unselected one sits at its idle level.
- R5: With the continuous bit set, the selected chip select stays asserted after the frame. With it clear, the selects return to idle when the frame ends.
- R6: A frame with the end-of-queue bit sets flag bit 1 when it completes. No new entry is taken while that flag is set, and clearing it resumes operation.
- R7: The transfer counter sits in xfer_count[31:16] with bits 15:0 zero. It adds one per completed frame. A frame with the clear bit leaves it at 1.
- R8: Flags are sticky and cleared by writing one on sts_clr. Bit 0 is set by every completed frame.
- R9: Flag bit 2 (TX underflow) is set when a frame with the continuous bit completes while the transmit queue is empty.
- R10: A frame completing into a full receive queue is discarded and sets flag bit 4. The stored words are unchanged.
- R11: ctl_flush_tx empties the transmit queue and ctl_flush_rx empties the receive queue, each in one cycle.
- R12: No frame starts while ctl_master_en is low. Queued entries wait.
- R13: Flag bit 3 is set each cycle the transmit queue has room, and flag bit 5 each cycle the receive queue holds data. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| push_valid | input | 1 | Push strobe for a transmit entry |
| push_data | input | 32 | Command and data entry |
| pop_req | input | 1 | Remove the oldest received word |
| pop_valid | output | 1 | Receive queue not empty |
| pop_data | output | 16 | Oldest received word |
| ctl_master_en | input | 1 | Enables master operation |
| ctl_flush_tx | input | 1 | Empties the transmit queue |
| ctl_flush_rx | input | 1 | Empties the receive queue |
| ctl_cs_idle | input | 6 | Inactive level per chip select |
| cfg_frame_size | input | 32 | Eight 4-bit frame-size fields, set 0 in the low bits |
| sts_flags | output | 6 | Sticky status flags |
| sts_clr | input | 6 | Write-one-to-clear strobes for the flags |
| xfer_count | output | 32 | Transfer counter in bits 31:16 |
| tick | input | 1 | Half-period strobe from the timing unit |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Chip selects |

## Verification
The checker watches on every cycle that sck stays low outside a frame, that the counter changes only at a frame end, that the done flag follows every frame, that the engine stays idle while the end-of-queue flag is set, that a receive flush leaves the queue empty, and that a frame ending into a full receive queue raises the overflow flag. Other behaviours can only be shown by the bench scenarios: bit order and frame length on the wire, width masking and short-field clamping, chip-select polarity and continuity, dropped pushes, the discarded overflow frame and the counter clear. The bench recovers the data on the wire through a loopback with optional inversion.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
   localparam int DATA_W     = 16;
   localparam int CS_W       = 6;
   localparam int SET_W      = 3;
   localparam int FMSZ_W     = 4;
   localparam int RSV_W      = 4;
   localparam int MIN_BITS   = 4;
   localparam int ENTRY_W    = 1 + SET_W + 1 + 1 + RSV_W + CS_W + DATA_W;

   localparam int FLG_DONE   = 0;
   localparam int FLG_EOQ    = 1;
   localparam int FLG_TXUF   = 2;
   localparam int FLG_TXREQ  = 3;
   localparam int FLG_RXOV   = 4;
   localparam int FLG_RXREQ  = 5;
   localparam int NUM_FLAGS  = 6;

   typedef struct packed {
      logic              cont;
      logic [SET_W-1:0]  set;
      logic              eoq;
      logic              clr;
      logic [RSV_W-1:0]  rsv;
      logic [CS_W-1:0]   pcs;
      logic [DATA_W-1:0] data;
   } push_entry_t;

   typedef struct packed {
      logic            cont;
      logic            eoq;
      logic            clr;
      logic [CS_W-1:0] pcs;
   } frame_cmd_t;
endpackage

// File: rtl/cqs_fifo.sv
module cqs_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("cqs_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] cnt;
   logic             do_wr, do_rd;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign do_wr   = wr_en && !full;
   assign do_rd   = rd_en && !empty;
   assign rd_data = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_wr) wptr <= wptr + PTR_W'(1);
         if (do_rd) rptr <= rptr + PTR_W'(1);
         cnt <= cnt + CNT_W'(do_wr) - CNT_W'(do_rd);
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr && !flush) mem[wptr] <= wr_data;
   end
endmodule

// File: rtl/cqs_shift_engine.sv
module cqs_shift_engine #(
   parameter int MAX_BITS = 16,
   parameter int LEN_W    = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                start,
   input  logic [MAX_BITS-1:0] ld_data,
   input  logic [LEN_W-1:0]    ld_len_m1,
   input  logic                miso,
   output logic                busy,
   output logic                sck,
   output logic                mosi,
   output logic                frame_done,
   output logic [MAX_BITS-1:0] rx_word
);
   logic                phase;
   logic [LEN_W-1:0]    bit_idx;
   logic [LEN_W-1:0]    len_q;
   logic [MAX_BITS-1:0] tx_sh;
   logic [MAX_BITS-1:0] rx_sh;
   logic [MAX_BITS-1:0] width_mask;
   logic                last_bit;

   assign last_bit   = (bit_idx == len_q);
   assign frame_done = busy && tick && phase && last_bit;
   assign mosi       = busy && tx_sh[len_q];

   always_comb begin
      for (int i = 0; i < MAX_BITS; i++) begin
         width_mask[i] = (LEN_W'(i) <= len_q);
      end
   end

   assign rx_word = rx_sh & width_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         phase   <= 1'b0;
         sck     <= 1'b0;
         bit_idx <= '0;
         len_q   <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         phase   <= 1'b0;
         sck     <= 1'b0;
         bit_idx <= '0;
         len_q   <= ld_len_m1;
         tx_sh   <= ld_data;
         rx_sh   <= '0;
      end else if (busy && tick) begin
         if (!phase) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[MAX_BITS-2:0], miso};
            phase <= 1'b1;
         end else begin
            sck   <= 1'b0;
            phase <= 1'b0;
            if (last_bit) begin
               busy <= 1'b0;
            end else begin
               bit_idx <= bit_idx + LEN_W'(1);
               tx_sh   <= tx_sh << 1;
            end
         end
      end
   end
endmodule

// File: rtl/cqs_status.sv
module cqs_status #(
   parameter int CNT_W = 16,
   parameter int NFLG  = cqs_pkg::NUM_FLAGS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_done,
   input  logic             cmd_cont,
   input  logic             cmd_eoq,
   input  logic             cmd_clr,
   input  logic             tx_empty,
   input  logic             tx_full,
   input  logic             rx_full,
   input  logic             rx_empty,
   input  logic [NFLG-1:0]  flag_clr,
   output logic [NFLG-1:0]  flags,
   output logic [CNT_W-1:0] tcnt
);
   import cqs_pkg::*;

   logic [NFLG-1:0] set_vec;

   always_comb begin
      set_vec            = '0;
      set_vec[FLG_DONE]  = frame_done;
      set_vec[FLG_EOQ]   = frame_done && cmd_eoq;
      set_vec[FLG_TXUF]  = frame_done && cmd_cont && tx_empty;
      set_vec[FLG_TXREQ] = !tx_full;
      set_vec[FLG_RXOV]  = frame_done && rx_full;
      set_vec[FLG_RXREQ] = !rx_empty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         tcnt  <= '0;
      end else begin
         flags <= (flags & ~flag_clr) | set_vec;
         if (frame_done) tcnt <= (cmd_clr ? '0 : tcnt) + CNT_W'(1);
      end
   end
endmodule

// File: rtl/cq_spi_master.sv
module cq_spi_master #(
   parameter int DEPTH    = 4,
   parameter int NUM_SETS = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  push_valid,
   input  logic [cqs_pkg::ENTRY_W-1:0]           push_data,
   input  logic                                  pop_req,
   output logic                                  pop_valid,
   output logic [cqs_pkg::DATA_W-1:0]            pop_data,
   input  logic                                  ctl_master_en,
   input  logic                                  ctl_flush_tx,
   input  logic                                  ctl_flush_rx,
   input  logic [cqs_pkg::CS_W-1:0]              ctl_cs_idle,
   input  logic [NUM_SETS*cqs_pkg::FMSZ_W-1:0]   cfg_frame_size,
   output logic [cqs_pkg::NUM_FLAGS-1:0]         sts_flags,
   input  logic [cqs_pkg::NUM_FLAGS-1:0]         sts_clr,
   output logic [2*cqs_pkg::DATA_W-1:0]          xfer_count,
   input  logic                                  tick,
   output logic                                  sck,
   output logic                                  mosi,
   input  logic                                  miso,
   output logic [cqs_pkg::CS_W-1:0]              cs_n
);
   import cqs_pkg::*;

   localparam int MIN_LEN_M1 = MIN_BITS - 1;

   generate
      if (!(DEPTH == 4 || DEPTH == 16)) begin : g_bad_depth
         $error("cq_spi_master: DEPTH must be 4 or 16");
      end
      if (NUM_SETS != (1 << SET_W)) begin : g_bad_sets
         $error("cq_spi_master: NUM_SETS must match the set field");
      end
      if (DATA_W != (1 << FMSZ_W)) begin : g_bad_fmsz
         $error("cq_spi_master: frame-size field must cover the data width");
      end
   endgenerate

   logic               tx_empty, tx_full, rx_empty, rx_full;
   logic [ENTRY_W-1:0] tx_rd_data;
   push_entry_t        tx_head;
   logic               eng_busy, frame_done, start;
   logic [DATA_W-1:0]  rx_word;
   logic [FMSZ_W-1:0]  raw_size, eff_size;
   frame_cmd_t         cur_cmd;
   logic [CS_W-1:0]    cs_act;
   logic [DATA_W-1:0]  tcnt;
   logic               unused_rsv;

   cqs_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(ctl_flush_tx),
      .wr_en(push_valid), .wr_data(push_data),
      .rd_en(start), .rd_data(tx_rd_data),
      .empty(tx_empty), .full(tx_full)
   );

   assign tx_head    = push_entry_t'(tx_rd_data);
   assign unused_rsv = ^tx_head.rsv;
   assign raw_size   = cfg_frame_size[tx_head.set*FMSZ_W +: FMSZ_W];
   assign eff_size   = (raw_size < FMSZ_W'(MIN_LEN_M1)) ? FMSZ_W'(MIN_LEN_M1) : raw_size;
   assign start      = !eng_busy && ctl_master_en && !sts_flags[FLG_EOQ] && !tx_empty;

   cqs_shift_engine #(.MAX_BITS(DATA_W), .LEN_W(FMSZ_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .ld_data(tx_head.data), .ld_len_m1(eff_size), .miso(miso),
      .busy(eng_busy), .sck(sck), .mosi(mosi),
      .frame_done(frame_done), .rx_word(rx_word)
   );

   cqs_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(ctl_flush_rx),
      .wr_en(frame_done), .wr_data(rx_word),
      .rd_en(pop_req), .rd_data(pop_data),
      .empty(rx_empty), .full(rx_full)
   );

   assign pop_valid = !rx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_cmd <= '0;
         cs_act  <= '0;
      end else if (start) begin
         cur_cmd <= '{cont: tx_head.cont, eoq: tx_head.eoq, clr: tx_head.clr, pcs: tx_head.pcs};
         cs_act  <= tx_head.pcs;
      end else if (frame_done && !cur_cmd.cont) begin
         cs_act  <= '0;
      end
   end

   generate
      for (genvar g = 0; g < CS_W; g++) begin : g_cs
         assign cs_n[g] = cs_act[g] ? ~ctl_cs_idle[g] : ctl_cs_idle[g];
      end
   endgenerate

   cqs_status #(.CNT_W(DATA_W), .NFLG(NUM_FLAGS)) u_sts (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
      .cmd_cont(cur_cmd.cont), .cmd_eoq(cur_cmd.eoq), .cmd_clr(cur_cmd.clr),
      .tx_empty(tx_empty), .tx_full(tx_full),
      .rx_full(rx_full), .rx_empty(rx_empty),
      .flag_clr(sts_clr), .flags(sts_flags), .tcnt(tcnt)
   );

   assign xfer_count = {tcnt, {DATA_W{1'b0}}};
endmodule

// File: rtl/cq_spi_master_chk.sv
module cq_spi_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        eng_busy,
   input logic        sck,
   input logic        frame_done,
   input logic        rx_full,
   input logic        ctl_flush_rx,
   input logic        pop_valid,
   input logic [5:0]  sts_flags,
   input logic [31:0] xfer_count
);
   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !sck);

   // R7
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(xfer_count[31:16]));

   // R8
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> sts_flags[0]);

   // R6
   eoq_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_flags[1] && !eng_busy) |=> !eng_busy);

   // R11
   rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_flush_rx |=> !pop_valid);

   // R10
   rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && rx_full) |=> sts_flags[4]);
endmodule

bind cq_spi_master cq_spi_master_chk chk_i (
   .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .sck(sck),
   .frame_done(frame_done), .rx_full(rx_full), .ctl_flush_rx(ctl_flush_rx),
   .pop_valid(pop_valid), .sts_flags(sts_flags), .xfer_count(xfer_count)
);

// File: tb/cq_spi_master_test.sv
module cq_spi_master_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [31:0] push_data = '0;
   logic        pop_req = 1'b0;
   logic        pop_valid;
   logic [15:0] pop_data;
   logic        ctl_master_en = 1'b1;
   logic        ctl_flush_tx = 1'b0;
   logic        ctl_flush_rx = 1'b0;
   logic [5:0]  ctl_cs_idle = 6'h3F;
   logic [31:0] cfg_frame_size = {4'd7, 4'd7, 4'd7, 4'd7, 4'd1, 4'd15, 4'd11, 4'd7};
   logic [5:0]  sts_flags;
   logic [5:0]  sts_clr = '0;
   logic [31:0] xfer_count;
   logic        tick = 1'b1;
   logic        sck, mosi, miso;
   logic [5:0]  cs_n;
   logic        miso_inv = 1'b0;

   int          checks = 0;
   int          failures = 0;
   int          mon_bits = 0;
   logic [15:0] mon_sh = '0;
   logic [5:0]  mon_cs = '0;

   assign miso = mosi ^ miso_inv;

   always #(CLK_PERIOD/2) clk = ~clk;

   cq_spi_master uut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
      .ctl_master_en(ctl_master_en), .ctl_flush_tx(ctl_flush_tx),
      .ctl_flush_rx(ctl_flush_rx), .ctl_cs_idle(ctl_cs_idle),
      .cfg_frame_size(cfg_frame_size), .sts_flags(sts_flags), .sts_clr(sts_clr),
      .xfer_count(xfer_count), .tick(tick), .sck(sck), .mosi(mosi),
      .miso(miso), .cs_n(cs_n)
   );

   always @(posedge sck) begin
      mon_bits = mon_bits + 1;
      mon_sh   = {mon_sh[14:0], mosi};
      mon_cs   = cs_n;
   end

   function automatic logic [31:0] mk(input logic cont, input logic [2:0] set,
                                      input logic eoq, input logic clr,
                                      input logic [5:0] pcs, input logic [15:0] d);
      return {cont, set, eoq, clr, 4'b0000, pcs, d};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] e);
      @(negedge clk); push_valid = 1'b1; push_data = e;
      @(negedge clk); push_valid = 1'b0;
   endtask

   task automatic pop_one();
      @(negedge clk); pop_req = 1'b1;
      @(negedge clk); pop_req = 1'b0;
   endtask

   task automatic flush_rx();
      @(negedge clk); ctl_flush_rx = 1'b1;
      @(negedge clk); ctl_flush_rx = 1'b0;
      chk("R11 rx flush", 32'(pop_valid), 32'd0);
   endtask

   task automatic clear_flags(input logic [5:0] m);
      @(negedge clk); sts_clr = m;
      @(negedge clk); sts_clr = '0;
   endtask

   task automatic settle(input int frames);
      repeat (frames * 40) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R4 reset cs idle", 32'(cs_n), 32'h3F);
      chk("R2 reset sck low", 32'(sck), 32'd0);
      chk("R7 reset counter", xfer_count, 32'd0);
      chk("R3 reset rx empty", 32'(pop_valid), 32'd0);
      chk("R8 reset flags", 32'(sts_flags[1:0]), 32'd0);
      repeat (2) @(negedge clk);
      chk("R13 tx room flag", 32'(sts_flags[3]), 32'd1);
      chk("R13 rx data flag idle", 32'(sts_flags[5]), 32'd0);
   endtask

   task automatic t_basic();
      int b0 = mon_bits;
      push(mk(1'b0, 3'd0, 1'b0, 1'b1, 6'b000001, 16'h00A5));
      settle(1);
      chk("R2 8-bit length", 32'(mon_bits - b0), 32'd8);
      chk("R2 msb first data", 32'(mon_sh[7:0]), 32'hA5);
      chk("R4 cs asserted low", 32'(mon_cs), 32'h3E);
      chk("R5 cs released", 32'(cs_n), 32'h3F);
      chk("R3 rx stored", 32'(pop_valid), 32'd1);
      chk("R3 rx data", 32'(pop_data), 32'h00A5);
      chk("R7 counter one", xfer_count, 32'h0001_0000);
      chk("R8 done flag", 32'(sts_flags[0]), 32'd1);
      chk("R13 rx data flag", 32'(sts_flags[5]), 32'd1);
      pop_one();
      chk("R3 popped", 32'(pop_valid), 32'd0);
      clear_flags(6'h3F);
      chk("R8 w1c done", 32'(sts_flags[1:0]), 32'd0);
      chk("R13 set wins", 32'(sts_flags[3]), 32'd1);
   endtask

   task automatic t_mask();
      int b0 = mon_bits;
      miso_inv = 1'b1;
      push(mk(1'b0, 3'd1, 1'b0, 1'b0, 6'b000001, 16'hFABC));
      settle(1);
      chk("R2 12-bit length", 32'(mon_bits - b0), 32'd12);
      chk("R2 12-bit data", 32'(mon_sh[11:0]), 32'hABC);
      chk("R3 masked rx", 32'(pop_data), 32'h0543);
      pop_one();
      miso_inv = 1'b0;
      b0 = mon_bits;
      push(mk(1'b0, 3'd3, 1'b0, 1'b0, 6'b000001, 16'h00F9));
      settle(1);
      chk("R2 short field clamps", 32'(mon_bits - b0), 32'd4);
      chk("R3 4-bit rx", 32'(pop_data), 32'h0009);
      chk("R7 counter three", xfer_count, 32'h0003_0000);
      pop_one();
   endtask

   task automatic t_count();
      for (int i = 0; i < 3; i++) push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000010, 16'(i)));
      settle(3);
      chk("R7 counter six", xfer_count, 32'h0006_0000);
      flush_rx();
      push(mk(1'b0, 3'd0, 1'b0, 1'b1, 6'b000010, 16'h0077));
      settle(1);
      chk("R7 clear restarts", xfer_count, 32'h0001_0000);
      flush_rx();
   endtask

   task automatic t_cont();
      clear_flags(6'h3F);
      push(mk(1'b1, 3'd0, 1'b0, 1'b0, 6'b000100, 16'h0011));
      settle(1);
      chk("R5 cs held", 32'(cs_n), 32'h3B);
      chk("R9 underflow", 32'(sts_flags[2]), 32'd1);
      push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000100, 16'h0022));
      settle(1);
      chk("R5 cs released after", 32'(cs_n), 32'h3F);
      chk("R7 counter three", xfer_count, 32'h0003_0000);
      flush_rx();
   endtask

   task automatic t_eoq();
      clear_flags(6'h3F);
      ctl_master_en = 1'b0;
      push(mk(1'b0, 3'd0, 1'b1, 1'b0, 6'b000010, 16'h0033));
      push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000010, 16'h0044));
      ctl_master_en = 1'b1;
      settle(2);
      chk("R6 eoq flag", 32'(sts_flags[1]), 32'd1);
      chk("R6 halted count", xfer_count, 32'h0004_0000);
      chk("R6 first data", 32'(pop_data), 32'h0033);
      chk("R6 cs idle halted", 32'(cs_n), 32'h3F);
      clear_flags(6'b000010);
      settle(1);
      chk("R6 resumed", xfer_count, 32'h0005_0000);
      chk("R6 flag clear", 32'(sts_flags[1]), 32'd0);
      flush_rx();
   endtask

   task automatic t_enable();
      ctl_master_en = 1'b0;
      push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000001, 16'h0055));
      settle(1);
      chk("R12 no frame", xfer_count, 32'h0005_0000);
      chk("R12 cs idle", 32'(cs_n), 32'h3F);
      ctl_master_en = 1'b1;
      settle(1);
      chk("R12 runs", xfer_count, 32'h0006_0000);
      flush_rx();
   endtask

   task automatic t_drop();
      ctl_master_en = 1'b0;
      for (int i = 0; i < 5; i++) push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000001, 16'(8'h60 + i)));
      clear_flags(6'b001000);
      chk("R13 no room", 32'(sts_flags[3]), 32'd0);
      ctl_master_en = 1'b1;
      settle(6);
      chk("R1 fifth dropped", xfer_count, 32'h000A_0000);
      chk("R1 first kept", 32'(pop_data), 32'h0060);
      chk("R10 no overflow", 32'(sts_flags[4]), 32'd0);
      chk("R13 room again", 32'(sts_flags[3]), 32'd1);
      flush_rx();
   endtask

   task automatic t_overflow();
      clear_flags(6'h3F);
      for (int i = 0; i < 5; i++) push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000001, 16'(8'h50 + i)));
      settle(6);
      chk("R10 overflow flag", 32'(sts_flags[4]), 32'd1);
      chk("R10 head kept", 32'(pop_data), 32'h0050);
      chk("R7 counter fifteen", xfer_count, 32'h000F_0000);
      for (int i = 0; i < 4; i++) begin
         chk("R10 stored order", 32'(pop_data), 32'(8'h50 + i));
         pop_one();
      end
      chk("R10 last discarded", 32'(pop_valid), 32'd0);
   endtask

   task automatic t_flush_tx();
      ctl_master_en = 1'b0;
      push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000001, 16'h0001));
      push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000001, 16'h0002));
      @(negedge clk); ctl_flush_tx = 1'b1;
      @(negedge clk); ctl_flush_tx = 1'b0;
      ctl_master_en = 1'b1;
      settle(2);
      chk("R11 tx flushed", xfer_count, 32'h000F_0000);
   endtask

   task automatic t_idle_pol();
      ctl_cs_idle = 6'b111110;
      @(negedge clk);
      chk("R4 idle level", 32'(cs_n), 32'h3E);
      push(mk(1'b0, 3'd0, 1'b0, 1'b0, 6'b000001, 16'h0081));
      settle(1);
      chk("R4 asserted high", 32'(mon_cs), 32'h3F);
      chk("R4 back to idle", 32'(cs_n), 32'h3E);
      ctl_cs_idle = 6'h3F;
      flush_rx();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_mask();
      t_count();
      t_cont();
      t_eoq();
      t_enable();
      t_drop();
      t_overflow();
      t_flush_tx();
      t_idle_pol();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule